// File: doc/BRIEF.md
# Byte and Word Memory Access Unit

This unit carries out the memory half of a small 16-bit processor's load and store instructions. When it is idle and sees a start strobe, it takes a base register value and an index and adds them to get an effective address. The index is either a second register value or a short unsigned immediate. It then performs one of four accesses over an 8-bit memory bus that uses a request/ready handshake:

- a low-byte load
- a low-byte store
- a 16-bit word load
- a 16-bit word store

Word accesses are split into two byte transactions in little-endian order. After a load, the unit gives the register file the assembled value and a per-lane write mask. On a byte load the mask enables only the low lane, so the destination's upper byte keeps its old contents.

Each access ends with a one-cycle done pulse. While an access is in flight, further start strobes are ignored. Instruction decode, the register file and the memory itself sit outside the block.

Top module: `lsu_byteword`

## Requirements
- R1: The effective address is the base value plus the selected index, taken modulo 2^16. The address of the second byte of a word access is also computed modulo 2^16, so base 0xFFFF addresses 0xFFFF and then 0x0000.
- R2: With `idx_imm_sel_i` = 1 the index is `idx_imm_i` zero-extended to 16 bits, and `idx_reg_i` is ignored. With `idx_imm_sel_i` = 0 the index is `idx_reg_i`, and `idx_imm_i` is ignored.
- R3: Opcode 2'b00 (byte load) makes one bus read at the effective address. It then presents `rd_data_o` = {8'h00, byte read} with `rd_we_o` = 2'b01, so only the low lane is written.
- R4: Opcode 2'b01 (byte store) makes exactly one bus write, at the effective address, with data `wdata_i[7:0]`.
- R5: Opcode 2'b10 (word load) reads the effective address and then the effective address plus one. It then presents `rd_data_o` = {second byte, first byte} with `rd_we_o` = 2'b11.
- R6: Opcode 2'b11 (word store) writes `wdata_i[7:0]` to the effective address, then writes `wdata_i[15:8]` to the effective address plus one.
- R7: Once `mem_req_o` is raised, it stays high, and address, write enable and write data stay unchanged, until a clock edge where `mem_rdy_i` is high. A transaction completes only on such an edge.
- R8: `done_o` is high for exactly one cycle, in the cycle right after the edge that completed the last transaction. `rd_we_o` is nonzero only while `done_o` is high, and stays 2'b00 for stores.
- R9: A start strobe from the cycle it is accepted through the done cycle has no effect. It does not change the bus transactions, the result, or the number of done pulses, and no request follows the done cycle.
- R10: While reset is active, `mem_req_o`, `done_o` and `rd_we_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an access (taken only when idle) |
| op_i | input | 2 | 00 byte load, 01 byte store, 10 word load, 11 word store |
| base_i | input | 16 | Base register value |
| idx_reg_i | input | 16 | Register index value |
| idx_imm_i | input | 4 | Unsigned immediate index |
| idx_imm_sel_i | input | 1 | 1 selects the immediate index, 0 the register index |
| wdata_i | input | 16 | Store data from the source register |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | Bus write enable |
| mem_addr_o | output | 16 | Bus byte address |
| mem_wdata_o | output | 8 | Bus write byte |
| mem_rdata_i | input | 8 | Bus read byte, valid with `mem_rdy_i` |
| mem_rdy_i | input | 1 | Bus ready; completes the current transaction |
| rd_data_o | output | 16 | Loaded value for the register file |
| rd_we_o | output | 2 | Register byte-lane write mask (bit 0 low lane) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach from the ports is a second start strobe arriving while a word access is stalled between its two byte transactions, or during the done cycle itself. A careless design would latch new operands there or start a third transaction. The bench drives such strobes by holding `start_i` high with inverted operands for the whole access. It also makes the memory model withhold `mem_rdy_i` at random, and for a fixed run of cycles in a directed case. Address wrap on the second byte is reached with directed bases at 0xFFFF and with base plus index sums past 0xFFFF.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    OP_LDB = 2'b00,
    OP_STB = 2'b01,
    OP_LDW = 2'b10,
    OP_STW = 2'b11
  } lsu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2
  } lsu_state_e;

endpackage

// File: rtl/lsu_rst_sync.sv
module lsu_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int AW   = 16,
  parameter int IMMW = 4
) (
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   idx_reg_i,
  input  logic [IMMW-1:0] idx_imm_i,
  input  logic            idx_imm_sel_i,
  output logic [AW-1:0]   ea_o
);

  logic [AW-1:0] idx_sel;

  always_comb begin
    if (idx_imm_sel_i) idx_sel = AW'(idx_imm_i);
    else               idx_sel = idx_reg_i;
    ea_o = base_i + idx_sel;
  end

endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = 8,
  localparam int NLANE = DW / BW,
  localparam int PHW   = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     op_i,
  input  logic [AW-1:0]  ea_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           mem_rdy_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [BW-1:0]  mem_wdata_o,
  output logic           accept_o,
  output logic           cap_o,
  output logic [PHW-1:0] lane_o,
  output logic           done_o,
  output logic           is_word_o,
  output logic           is_load_o
);

  lsu_state_e     st_q, st_d;
  logic [PHW-1:0] ph_q, ph_d;
  logic [AW-1:0]  ea_q;
  logic [DW-1:0]  wd_q;
  lsu_op_e        op_q;
  logic [PHW-1:0] last_ph;
  logic           hs;

  assign accept_o  = (st_q == ST_IDLE) && start_i;
  assign mem_req_o = (st_q == ST_BUS);
  assign hs        = mem_req_o && mem_rdy_i;
  assign is_word_o = op_q[1];
  assign is_load_o = !op_q[0];
  assign last_ph   = is_word_o ? PHW'(NLANE - 1) : '0;

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_BUS;
        ph_d = '0;
      end
      ST_BUS: if (mem_rdy_i) begin
        if (ph_q == last_ph) st_d = ST_DONE;
        else                 ph_d = ph_q + PHW'(1);
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q <= '0;
      wd_q <= '0;
      op_q <= OP_LDB;
    end else if (accept_o) begin
      ea_q <= ea_i;
      wd_q <= wdata_i;
      op_q <= lsu_op_e'(op_i);
    end
  end

  assign mem_we_o    = op_q[0];
  assign mem_addr_o  = ea_q + AW'(ph_q);
  assign mem_wdata_o = wd_q[ph_q*BW +: BW];
  assign cap_o       = hs && is_load_o;
  assign lane_o      = ph_q;
  assign done_o      = (st_q == ST_DONE);

  p_bus_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o) &&
                                 $stable(mem_we_o) && $stable(mem_wdata_o));

  p_word_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs && is_word_o && (ph_q == '0) |=>
      mem_req_o && (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(hs));

  p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !mem_req_o);

endmodule

// File: rtl/lsu_ldbuf.sv
module lsu_ldbuf #(
  parameter int DW = 16,
  parameter int BW = 8,
  localparam int NLANE = DW / BW,
  localparam int PHW   = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             cap_i,
  input  logic [PHW-1:0]   lane_i,
  input  logic [BW-1:0]    rdata_i,
  input  logic             done_i,
  input  logic             is_word_i,
  input  logic             is_load_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [NLANE-1:0] rd_we_o
);

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic          en;
    logic [BW-1:0] d;
    logic [BW-1:0] q;

    always_comb begin
      en = clear_i || (cap_i && (lane_i == PHW'(k)));
      d  = clear_i ? '0 : rdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign rd_data_o[k*BW +: BW] = q;
  end

  always_comb begin
    rd_we_o = '0;
    if (done_i && is_load_i) rd_we_o = is_word_i ? '1 : NLANE'(1);
  end

  p_mask_in_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we_o != '0) |-> done_i);

endmodule

// File: rtl/lsu_byteword.sv
module lsu_byteword #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int BW   = 8,
  parameter int IMMW = 4,
  localparam int NLANE = DW / BW,
  localparam int PHW   = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    idx_reg_i,
  input  logic [IMMW-1:0]  idx_imm_i,
  input  logic             idx_imm_sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [BW-1:0]    mem_wdata_o,
  input  logic [BW-1:0]    mem_rdata_i,
  input  logic             mem_rdy_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [NLANE-1:0] rd_we_o,
  output logic             done_o
);

  logic           rst_n_s;
  logic [AW-1:0]  ea;
  logic           accept;
  logic           cap;
  logic [PHW-1:0] lane;
  logic           is_word;
  logic           is_load;

  lsu_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  lsu_agen #(.AW(AW), .IMMW(IMMW)) u_agen (
    .base_i        (base_i),
    .idx_reg_i     (idx_reg_i),
    .idx_imm_i     (idx_imm_i),
    .idx_imm_sel_i (idx_imm_sel_i),
    .ea_o          (ea)
  );

  lsu_ctrl #(.AW(AW), .DW(DW), .BW(BW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start_i),
    .op_i        (op_i),
    .ea_i        (ea),
    .wdata_i     (wdata_i),
    .mem_rdy_i   (mem_rdy_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .accept_o    (accept),
    .cap_o       (cap),
    .lane_o      (lane),
    .done_o      (done_o),
    .is_word_o   (is_word),
    .is_load_o   (is_load)
  );

  lsu_ldbuf #(.DW(DW), .BW(BW)) u_ldbuf (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clear_i   (accept),
    .cap_i     (cap),
    .lane_i    (lane),
    .rdata_i   (mem_rdata_i),
    .done_i    (done_o),
    .is_word_i (is_word),
    .is_load_i (is_load),
    .rd_data_o (rd_data_o),
    .rd_we_o   (rd_we_o)
  );

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n_s |-> !mem_req_o && !done_o && (rd_we_o == '0));

endmodule

// File: tb/lsu_byteword_tb.sv
module lsu_byteword_tb;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  op_i;
  logic [15:0] base_i;
  logic [15:0] idx_reg_i;
  logic [3:0]  idx_imm_i;
  logic        idx_imm_sel_i;
  logic [15:0] wdata_i;
  logic        mem_req_o;
  logic        mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;
  logic        mem_rdy_i;
  logic [15:0] rd_data_o;
  logic [1:0]  rd_we_o;
  logic        done_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_hs_cyc = 0;
  int wr_n = 0;
  int rd_n = 0;
  int stall_n = 0;
  logic [15:0] wr_a [4];
  logic [7:0]  wr_d [4];

  lsu_byteword u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .base_i(base_i), .idx_reg_i(idx_reg_i), .idx_imm_i(idx_imm_i),
    .idx_imm_sel_i(idx_imm_sel_i), .wdata_i(wdata_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i),
    .rd_data_o(rd_data_o), .rd_we_o(rd_we_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  function automatic logic [15:0] calc_ea(input logic [15:0] b, input logic [15:0] ir,
                                          input logic [3:0] im, input logic s);
    return b + (s ? {12'h000, im} : ir);
  endfunction

  always @(negedge clk) begin
    if (stall_n > 0) begin
      stall_n = stall_n - 1;
      mem_rdy_i = 1'b0;
    end else begin
      mem_rdy_i = mem_req_o && ($urandom_range(0, 2) != 0);
    end
    mem_rdata_i = 8'h00;
    if (mem_req_o && mem_rdy_i) begin
      last_hs_cyc = cyc;
      mem_rdata_i = mem_byte(mem_addr_o);
      if (mem_we_o) begin
        if (wr_n < 4) begin
          wr_a[wr_n] = mem_addr_o;
          wr_d[wr_n] = mem_wdata_o;
        end
        wr_n = wr_n + 1;
      end else begin
        rd_n = rd_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] base,
                        input logic [15:0] ir, input logic [3:0] im, input logic s,
                        input logic [15:0] wd, input bit poke, input int stall);
    logic [15:0] ea;
    logic [15:0] exp_d;
    int beats;
    int waitc;
    ea    = calc_ea(base, ir, im, s);
    beats = op[1] ? 2 : 1;
    @(negedge clk);
    wr_n = 0; rd_n = 0; stall_n = stall;
    start_i = 1'b1; op_i = op; base_i = base; idx_reg_i = ir;
    idx_imm_i = im; idx_imm_sel_i = s; wdata_i = wd;
    @(negedge clk);
    if (poke) begin
      op_i = ~op; base_i = ~base; idx_reg_i = ~ir; idx_imm_i = ~im; wdata_i = ~wd;
    end else begin
      start_i = 1'b0;
    end
    waitc = 0;
    while (!done_o && waitc < 300) begin
      @(negedge clk);
      waitc++;
    end
    start_i = 1'b0;
    chk(done_o, "R8 done seen", {31'd0, done_o}, 32'd1);
    chk(cyc == last_hs_cyc + 1, "R8 done timing", cyc, last_hs_cyc + 1);
    if (stall > 0) chk(waitc >= stall, "R7 stall respected", waitc, stall);
    if (!op[0]) begin
      exp_d = op[1] ? {mem_byte(ea + 16'd1), mem_byte(ea)} : {8'h00, mem_byte(ea)};
      chk(rd_data_o == exp_d, op[1] ? "R5 R1 R2 load data" : "R3 R1 R2 load data",
          rd_data_o, exp_d);
      chk(rd_we_o == (op[1] ? 2'b11 : 2'b01), op[1] ? "R5 mask" : "R3 mask",
          rd_we_o, op[1] ? 2'b11 : 2'b01);
      chk(rd_n == beats && wr_n == 0, "R9 R5 read count", rd_n, beats);
    end else begin
      chk(rd_we_o == 2'b00, "R8 store mask", rd_we_o, 2'b00);
      chk(wr_n == beats && rd_n == 0, "R9 R4 write count", wr_n, beats);
      chk(wr_a[0] == ea && wr_d[0] == wd[7:0], "R4 R6 R1 R2 first byte",
          {wr_a[0], wr_d[0]}, {ea, wd[7:0]});
      if (op[1])
        chk(wr_a[1] == ea + 16'd1 && wr_d[1] == wd[15:8], "R6 R1 second byte",
            {wr_a[1], wr_d[1]}, {ea + 16'd1, wd[15:8]});
    end
    @(negedge clk);
    chk(!done_o && !mem_req_o && rd_we_o == 2'b00, "R8 R9 quiet after done",
        {done_o, mem_req_o, rd_we_o}, 0);
    @(negedge clk);
    chk(!mem_req_o, "R9 no late request", {31'd0, mem_req_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0027));
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; base_i = '0; idx_reg_i = '0;
    idx_imm_i = '0; idx_imm_sel_i = 1'b0; wdata_i = '0;
    mem_rdy_i = 1'b0; mem_rdata_i = '0;
    repeat (3) @(negedge clk);
    chk(!mem_req_o && !done_o && rd_we_o == 2'b00, "R10 reset state",
        {mem_req_o, done_o, rd_we_o}, 0);
    start_i = 1'b1;
    @(negedge clk);
    chk(!mem_req_o, "R10 start held in reset", {31'd0, mem_req_o}, 0);
    start_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 byte load, R2 immediate selected over a nonzero register index
    run_op(2'b00, 16'h1230, 16'hBEEF, 4'hF, 1'b1, 16'h0000, 1'b0, 0);
    // R2 register selected, immediate ignored
    run_op(2'b00, 16'h2000, 16'h0123, 4'h7, 1'b0, 16'h0000, 1'b0, 0);
    // R4 byte store
    run_op(2'b01, 16'h4000, 16'h0011, 4'h0, 1'b0, 16'hAB5C, 1'b0, 0);
    // R5 word load wrapping across 0xFFFF, R1
    run_op(2'b10, 16'hFFFF, 16'h0000, 4'h0, 1'b1, 16'h0000, 1'b0, 0);
    // R6 word store wrapping across 0xFFFF
    run_op(2'b11, 16'hFFF0, 16'h0000, 4'hF, 1'b1, 16'hC3D4, 1'b0, 0);
    // R1 sum past 0xFFFF
    run_op(2'b10, 16'hFFF8, 16'h0010, 4'h0, 1'b0, 16'h0000, 1'b0, 0);
    // R7 long stall on each kind
    run_op(2'b10, 16'h0100, 16'h0002, 4'h0, 1'b0, 16'h0000, 1'b0, 7);
    run_op(2'b11, 16'h0200, 16'h0000, 4'h3, 1'b1, 16'h9876, 1'b0, 5);
    // R9 start held high throughout the access
    run_op(2'b11, 16'h0300, 16'h0000, 4'h1, 1'b1, 16'h1357, 1'b1, 3);
    run_op(2'b00, 16'h0400, 16'h0005, 4'h0, 1'b0, 16'h0000, 1'b1, 0);

    for (int i = 0; i < 60; i++) begin
      run_op(2'($urandom_range(0, 3)), 16'($urandom), 16'($urandom),
             4'($urandom), 1'($urandom), 16'($urandom),
             ($urandom_range(0, 3) == 0), $urandom_range(0, 4));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule